// File: doc/BRIEF.md
# Parallel Result Bus Formatter

This block places an 18-bit conversion result onto an 18-line output bus. It supports three parallel widths: full, word and byte. In word and byte width, an address selects which slice of the result appears. The lines that are not used for data either act as control inputs (address and code select) or stay undriven. The block produces a data value and an output enable for every line. The pad ring combines each pair into a tri-state driver.

The host reads a result by pulling chip select and read low. While either strobe is high, every output enable is low. The fourth mode setting hands the pins to a serial port, and in that mode this block drives nothing. Outside full width, a code select input picks between straight binary and two's complement. Two's complement is formed by flipping the result MSB. All outputs are registered and follow the inputs one clock later.

Top module: `par_result_bus`

## Requirements
- R1: When rst_n is low at a rising clock edge, bus_data and bus_oe are all zeros after that edge.
- R2: bus_data and bus_oe follow the inputs sampled at the previous rising edge, with exactly one cycle of latency.
- R3: The bus is enabled only when cs_n and rd_n are both low. Otherwise, all 18 bits of bus_oe are 0.
- R4: width_mode encodes the bus width: 2'b00 is full 18-bit, 2'b01 is 16-bit word, 2'b10 is 8-bit byte, and 2'b11 is serial. In serial mode, all bits of bus_oe are 0.
- R5: In full width, all 18 lines drive result bit for bit. code_bin and addr have no effect.
- R6: In word and byte width, code_bin high gives straight binary. code_bin low inverts result bit 17 before the slice is taken.
- R7: In word width, lines 1:0 are never driven. With addr[0]=0, lines 17:2 carry coded bits 17:2. With addr[0]=1, lines 17:2 carry coded bits 15:0.
- R8: In byte width, lines 9:0 are never driven, and lines 17:10 carry a byte selected by addr[1:0]. The settings are: 2'b00 gives coded bits 17:10; 2'b01 gives coded bits 9:2; 2'b10 and 2'b11 both give {coded[1:0], 6'b0}, with coded[1] on line 17.
- R9: A line whose bus_oe bit is 0 shows 0 on bus_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| width_mode | input | 2 | Bus width / serial select |
| addr | input | 2 | Slice address for word and byte width |
| code_bin | input | 1 | 1 = straight binary, 0 = two's complement |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| result | input | 18 | Latched conversion result |
| bus_data | output | 18 | Per-line output value |
| bus_oe | output | 18 | Per-line output enable |

## Verification
Full width is driven with alternating, walking and all-ones results while code_bin and addr toggle. This shows whether the full path ignores both. Word and byte width are run with results whose slices are all different, across every address and both code settings. A wrong slice, shift or MSB flip therefore shows up as a distinct value. The strobe combinations and serial mode check that the enables fall. Finally, a long pseudo-random run over all inputs, including resets taken mid-stream, is compared every clock against a per-line behavioural model. This run separates latency errors from mapping errors.

// File: rtl/pbf_pkg.sv
// Shared types for the parallel result bus formatter.
// Assumes the mode pins are decoded exactly as the enum lists them.
package pbf_pkg;
    typedef enum logic [1:0] {
        WM_FULL = 2'b00,
        WM_WORD = 2'b01,
        WM_BYTE = 2'b10,
        WM_SER  = 2'b11
    } wmode_t;
endpackage

// File: rtl/pbf_code_sel.sv
// Applies the output code to the result before slicing.
// Full width is always straight binary. Other widths flip the MSB when
// code_bin is low. Assumes RES_W >= 1.
module pbf_code_sel
    import pbf_pkg::*;
#(
    parameter int RES_W = 18
) (
    input  wmode_t             mode,
    input  logic               code_bin,
    input  logic [RES_W-1:0]   result,
    output logic [RES_W-1:0]   coded
);
    // Flip the MSB only for two's complement outside full width.
    always_comb begin
        coded = result;
        if (mode != WM_FULL && !code_bin)
            coded[RES_W-1] = ~result[RES_W-1];
    end
endmodule

// File: rtl/pbf_slice_mux.sv
// Chooses the per-line value and drive request for each bus width.
// Word data occupies the top WORD_W lines. Byte data occupies the top
// BYTE_W lines. Assumes 2*BYTE_W < RES_W <= 3*BYTE_W and WORD_W < RES_W.
module pbf_slice_mux
    import pbf_pkg::*;
#(
    parameter int RES_W  = 18,
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  wmode_t             mode,
    input  logic [1:0]         addr,
    input  logic [RES_W-1:0]   raw,
    input  logic [RES_W-1:0]   coded,
    output logic [RES_W-1:0]   line_val,
    output logic [RES_W-1:0]   line_drv
);
    localparam int WORD_SH = RES_W - WORD_W;
    localparam int BYTE_LO = RES_W - BYTE_W;
    localparam int LOW_W   = RES_W - 2 * BYTE_W;
    localparam int FILL_W  = BYTE_W - LOW_W;

    logic [BYTE_W-1:0] byte_hi, byte_mid, byte_low;

    // Form the three candidate bytes from the coded result.
    always_comb begin
        byte_hi  = coded[RES_W-1 -: BYTE_W];
        byte_mid = coded[BYTE_LO-1 -: BYTE_W];
        byte_low = {coded[LOW_W-1:0], {FILL_W{1'b0}}};
    end

    // Route the selected slice onto the lines and mark which lines drive.
    always_comb begin
        line_val = '0;
        line_drv = '0;
        unique case (mode)
            WM_FULL: begin
                line_val = raw;
                line_drv = '1;
            end
            WM_WORD: begin
                line_val[RES_W-1:WORD_SH] = addr[0] ? coded[WORD_W-1:0]
                                                    : coded[RES_W-1:WORD_SH];
                line_drv[RES_W-1:WORD_SH] = '1;
            end
            WM_BYTE: begin
                unique case (addr)
                    2'b00:   line_val[RES_W-1:BYTE_LO] = byte_hi;
                    2'b01:   line_val[RES_W-1:BYTE_LO] = byte_mid;
                    default: line_val[RES_W-1:BYTE_LO] = byte_low;
                endcase
                line_drv[RES_W-1:BYTE_LO] = '1;
            end
            default: begin
                line_val = '0;
                line_drv = '0;
            end
        endcase
    end
endmodule

// File: rtl/pbf_lane_reg.sv
// Registers one value/enable pair per bus line.
// A line that is not driven holds 0 on its data bit. Reset is synchronous
// and active low.
module pbf_lane_reg #(
    parameter int RES_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic [RES_W-1:0]   line_val,
    input  logic [RES_W-1:0]   line_drv,
    output logic [RES_W-1:0]   q_data,
    output logic [RES_W-1:0]   q_oe
);
    for (genvar i = 0; i < RES_W; i++) begin : g_lane
        // Capture one line's enable and gated value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_oe[i]   <= 1'b0;
                q_data[i] <= 1'b0;
            end else begin
                q_oe[i]   <= bus_en & line_drv[i];
                q_data[i] <= bus_en & line_drv[i] & line_val[i];
            end
        end
    end
endmodule

// File: rtl/par_result_bus.sv
// Top level of the parallel result bus formatter.
// It applies the code select, picks the slice for the bus width, and
// registers the per-line data and enable. Assumes the pad ring forms the
// tri-state drivers and feeds the reused control pins in as addr/code_bin.
module par_result_bus
    import pbf_pkg::*;
#(
    parameter int RES_W  = 18,
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         width_mode,
    input  logic [1:0]         addr,
    input  logic               code_bin,
    input  logic               cs_n,
    input  logic               rd_n,
    input  logic [RES_W-1:0]   result,
    output logic [RES_W-1:0]   bus_data,
    output logic [RES_W-1:0]   bus_oe
);
    localparam int WORD_SH = RES_W - WORD_W;
    localparam int BYTE_LO = RES_W - BYTE_W;

    wmode_t           mode;
    logic             bus_en;
    logic [RES_W-1:0] coded, line_val, line_drv;

    // Decode the width pins and the read strobes.
    always_comb begin
        mode   = wmode_t'(width_mode);
        bus_en = !cs_n && !rd_n;
    end

    pbf_code_sel #(.RES_W(RES_W)) u_code (
        .mode(mode), .code_bin(code_bin), .result(result), .coded(coded)
    );

    pbf_slice_mux #(.RES_W(RES_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_mux (
        .mode(mode), .addr(addr), .raw(result), .coded(coded),
        .line_val(line_val), .line_drv(line_drv)
    );

    pbf_lane_reg #(.RES_W(RES_W)) u_lanes (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en),
        .line_val(line_val), .line_drv(line_drv),
        .q_data(bus_data), .q_oe(bus_oe)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (bus_oe == '0 && bus_data == '0));

    assert_strobe_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |=> bus_oe == '0);

    assert_serial_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (width_mode == 2'b11) |=> bus_oe == '0);

    assert_full_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (width_mode == 2'b00 && !cs_n && !rd_n)
        |=> (bus_data == $past(result) && bus_oe == '1));

    assert_word_ctrl_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (width_mode == 2'b01) |=> bus_oe[WORD_SH-1:0] == '0);

    assert_byte_low_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (width_mode == 2'b10) |=> bus_oe[BYTE_LO-1:0] == '0);

    assert_undriven_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_data & ~bus_oe) == '0);
endmodule

// File: tb/sim_par_result_bus.sv
module sim_par_result_bus;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  width_mode = 2'b00;
    logic [1:0]  addr = 2'b00;
    logic        code_bin = 1'b1;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic [17:0] result = '0;
    logic [17:0] bus_data, bus_oe;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string tag_in = "R1";
    string tag_q = "R1";
    logic [17:0] exp_data = '0;
    logic [17:0] exp_oe = '0;

    par_result_bus u0 (
        .clk(clk), .rst_n(rst_n), .width_mode(width_mode), .addr(addr),
        .code_bin(code_bin), .cs_n(cs_n), .rd_n(rd_n), .result(result),
        .bus_data(bus_data), .bus_oe(bus_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural per-line model of the requirements.
    function automatic void model(input logic [1:0] m, input logic [1:0] a,
                                  input logic b, input logic c, input logic r,
                                  input logic [17:0] v,
                                  output logic [17:0] d, output logic [17:0] e);
        logic [17:0] w;
        d = '0;
        e = '0;
        if (c || r || m == 2'd3) return;      // R3, R4
        w = v;
        if (m != 2'd0 && !b) w[17] = ~w[17];  // R6
        for (int i = 0; i < 18; i++) begin
            if (m == 2'd0) begin               // R5
                e[i] = 1'b1;
                d[i] = v[i];
            end else if (m == 2'd1 && i >= 2) begin   // R7
                e[i] = 1'b1;
                d[i] = a[0] ? w[i-2] : w[i];
            end else if (m == 2'd2 && i >= 10) begin  // R8
                int k;
                k = i - 10;
                e[i] = 1'b1;
                if (a == 2'd0)      d[i] = w[10+k];
                else if (a == 2'd1) d[i] = w[2+k];
                else                d[i] = (k >= 6) ? w[k-6] : 1'b0;
            end
        end
    endfunction

    // Advance the model once per rising edge.
    always @(posedge clk) begin
        logic [17:0] d, e;
        cycles++;
        tag_q = tag_in;
        if (!rst_n) begin
            exp_data = '0;
            exp_oe   = '0;
        end else begin
            model(width_mode, addr, code_bin, cs_n, rd_n, result, d, e);
            exp_data = d;
            exp_oe   = e;
        end
    end

    // Compare the outputs away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (bus_data !== exp_data || bus_oe !== exp_oe) begin
                n_fail++;
                $display("FAIL %s data=%h exp=%h oe=%h exp_oe=%h",
                         tag_q, bus_data, exp_data, bus_oe, exp_oe);
            end
        end
    end

    // End a hung run as a failure.
    always @(posedge clk) begin
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic put(input logic [1:0] m, input logic [1:0] a, input logic b,
                       input logic c, input logic r, input logic [17:0] v,
                       input string t);
        @(negedge clk);
        width_mode = m; addr = a; code_bin = b; cs_n = c; rd_n = r;
        result = v; tag_in = t;
    endtask

    initial begin
        logic [31:0] lfsr;
        // R1: reset with an enabled full-width read pending
        put(2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 18'h3ffff, "R1");
        put(2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 18'h3ffff, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        // R5: full width ignores code_bin and addr
        put(2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 18'h2aaaa, "R5");
        put(2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 18'h15555, "R5");
        put(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 18'h20001, "R5");
        // R3: either strobe high disables the bus
        put(2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 18'h3ffff, "R3");
        put(2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 18'h3ffff, "R3");
        put(2'd2, 2'd0, 1'b1, 1'b1, 1'b1, 18'h3ffff, "R3");
        // R4: serial mode drives nothing
        put(2'd3, 2'd0, 1'b1, 1'b0, 1'b0, 18'h3ffff, "R4");
        put(2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 18'h12345, "R4");
        // R7 / R6: word width, both addresses, both codes
        put(2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 18'h2b3c5, "R7");
        put(2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 18'h2b3c5, "R7");
        put(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 18'h2b3c5, "R6");
        put(2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 18'h1b3c7, "R6");
        // R8 / R6: byte width, every address
        for (int s = 0; s < 4; s++)
            put(2'd2, s[1:0], 1'b1, 1'b0, 1'b0, 18'h3a5c3, "R8");
        put(2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 18'h3a5c3, "R6");
        put(2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 18'h00002, "R8");
        // R2 / R9: pseudo-random stream with occasional reset
        lfsr = 32'h1ace_b00c;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            put(lfsr[1:0], lfsr[3:2], lfsr[4], lfsr[5] & lfsr[6],
                lfsr[7] & lfsr[8], lfsr[27:10], (n % 2 == 0) ? "R2" : "R9");
            if (lfsr[31:28] == 4'hf) rst_n = 1'b0;
            else rst_n = 1'b1;
        end
        rst_n = 1'b1;
        put(2'd0, 2'd0, 1'b1, 1'b1, 1'b1, '0, "R3");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule